// File: doc/BRIEF.md
# Persistence-Aware Cache Replacement Controller

This block keeps the tags, valid bits and recency state of a set-associative cache and picks the way that each request lands in. Part of every set can be held back for lines that software has marked as persisting. Each request names a set, a tag and a one-bit hint: persisting or normal (streaming). A hit refreshes that line's recency. A miss picks a victim way that the hint and the reservation allow, installs the new tag there at once, and reports which line was pushed out. The data array and the refill path sit outside this block.

The reservation is a way count R. Ways below R form the reserved region and the rest form the normal region. Recency is ranked separately inside each region, so a flood of streaming misses can only ever recycle normal ways. R is taken from the configuration input only during the clear sweep that follows reset or a flush. A new value therefore takes effect only with an empty cache, and no line ever sits in the wrong region.

Control has two states. ST_CLEAR walks through the sets, one per cycle, marking every way invalid and resetting its recency rank. ST_READY accepts requests. The transitions are T_SWEEP_DONE (ST_CLEAR to ST_READY once the last set is cleared), T_FLUSH (ST_READY to ST_CLEAR when flush is high) and T_RESTART (flush during ST_CLEAR starts the sweep again from set 0).

Top module: `persist_repl_ctrl`

## Requirements
- R1: After reset is released, req_ready stays low for exactly SETS cycles. After a flush is sampled, it stays low for SETS+1 cycles. After either sweep every way of every set is invalid, so the first access to any set misses with rsp_evict_valid low.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. rsp_valid is high in exactly the next cycle and in no other.
- R3: If the request tag equals the tag of a valid way in the addressed set, rsp_hit is 1, rsp_way is that way and rsp_evict_valid is 0, whatever the hint. The line stays in its way.
- R4: With R = 0, a miss takes the least recently accessed way among all ways of the set, for either hint value.
- R5: With R > 0, a miss with req_persist = 1 selects a way with index below R.
- R6: A miss with req_persist = 0 always selects a way with index R or above.
- R7: On a miss, an invalid way in the allowed region is chosen before any valid way, and the lowest-indexed invalid way wins.
- R8: When every allowed way is valid, the victim is the allowed way that was least recently hit or installed.
- R9: A miss that replaces a valid way raises rsp_evict_valid and returns the replaced tag on rsp_evict_tag. A later request for the new tag hits in that way.
- R10: R is taken from cfg_resv only during the clear sweep. Changing cfg_resv while in ST_READY does not change victim selection until the next flush.
- R11: While flush is high, req_ready is low and no request is accepted. Flush wins over a request presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous request to invalidate all lines |
| cfg_resv | input | $clog2(WAYS) | Number of reserved ways, taken during the clear sweep |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_set | input | $clog2(SETS) | Set index of the request |
| req_tag | input | TAG_W | Tag of the request |
| req_persist | input | 1 | 1 = persisting hint, 0 = normal or streaming |
| rsp_valid | output | 1 | Response present, one cycle after acceptance |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | $clog2(WAYS) | Way hit or way filled |
| rsp_evict_valid | output | 1 | A valid line was replaced |
| rsp_evict_tag | output | TAG_W | Tag of the replaced line |

## Verification
The bench aims at the region boundary. A streaming miss that lands in a reserved way, or a persisting miss that escapes into the normal region, would show up as a wrong rsp_way. The fallback case R = 0 is also covered: a design that still kept a reserved region there would pick a way outside plain LRU order. The bench also checks recency after a cross-hint hit, where a wrongly ranked region picks a stale victim. It changes cfg_resv without a flush, which a design that samples too eagerly would follow at once. Finally it presents a request together with a flush, which a design would wrongly accept or answer.

// File: rtl/persist_repl_pkg.sv
package persist_repl_pkg;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_READY = 1'b1
    } repl_state_e;

endpackage

// File: rtl/prc_tag_match.sv
module prc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 12,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]           lookup_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match_vec;

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_cmp
        assign match_vec[gi] = line_valid[gi] && (line_tag[gi] == lookup_tag);
    end

    always_comb begin
        hit     = |match_vec;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_way = WAY_W'(i);
        end
    end

endmodule

// File: rtl/prc_victim_pick.sv
module prc_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            line_valid,
    input  logic [WAYS-1:0][WAY_W-1:0] line_age,
    input  logic [WAY_W-1:0]           resv_ways,
    input  logic                       use_resv,
    output logic [WAY_W-1:0]           victim
);

    logic [WAYS-1:0] allowed;

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_elig
        localparam logic [WAY_W-1:0] IDX = WAY_W'(gi);
        assign allowed[gi] = use_resv ? (IDX < resv_ways) : (IDX >= resv_ways);
    end

    logic             have_free;
    logic [WAY_W-1:0] free_way;
    logic             have_old;
    logic [WAY_W-1:0] old_way;
    logic [WAY_W-1:0] old_age;

    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (allowed[i] && !line_valid[i]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(i);
            end
        end
        have_old = 1'b0;
        old_way  = '0;
        old_age  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (allowed[i] && (!have_old || line_age[i] > old_age)) begin
                have_old = 1'b1;
                old_way  = WAY_W'(i);
                old_age  = line_age[i];
            end
        end
        victim = have_free ? free_way : old_way;
    end

endmodule

// File: rtl/prc_age_update.sv
module prc_age_update #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]           touch_way,
    input  logic [WAY_W-1:0]           resv_ways,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);

    logic             touch_resv;
    logic [WAY_W-1:0] touch_age;

    assign touch_resv = touch_way < resv_ways;
    assign touch_age  = age_in[touch_way];

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_rank
        localparam logic [WAY_W-1:0] IDX = WAY_W'(gi);
        logic same_region;
        assign same_region = ((IDX < resv_ways) == touch_resv);
        always_comb begin
            if (IDX == touch_way)
                age_out[gi] = '0;
            else if (same_region && (age_in[gi] < touch_age))
                age_out[gi] = age_in[gi] + 1'b1;
            else
                age_out[gi] = age_in[gi];
        end
    end

endmodule

// File: rtl/persist_repl_ctrl.sv
module persist_repl_ctrl
    import persist_repl_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 8,
    parameter int TAG_W = 12,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [WAY_W-1:0] cfg_resv,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SET_W-1:0] req_set,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_persist,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic             rsp_evict_valid,
    output logic [TAG_W-1:0] rsp_evict_tag
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

    repl_state_e      state_q, state_d;
    logic [SET_W-1:0] clr_idx_q;
    logic [WAY_W-1:0] resv_q;
    logic             clearing;
    logic             accept;

    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0][WAY_W-1:0] age_q   [SETS];

    logic [WAYS-1:0]            cur_valid;
    logic [WAYS-1:0][TAG_W-1:0] cur_tag;
    logic [WAYS-1:0][WAY_W-1:0] cur_age;
    logic [WAYS-1:0][WAY_W-1:0] next_age;
    logic [WAYS-1:0][WAY_W-1:0] fresh_age;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic [WAY_W-1:0] sel_way;
    logic             use_resv;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_CLEAR;
            clr_idx_q <= '0;
            resv_q    <= '0;
        end else begin
            state_q <= state_d;
            if (flush)
                clr_idx_q <= '0;
            else if (state_q == ST_CLEAR)
                clr_idx_q <= (clr_idx_q == LAST_SET) ? '0 : clr_idx_q + 1'b1;
            if (state_q == ST_CLEAR)
                resv_q <= cfg_resv;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (flush)                        state_d = ST_CLEAR; // T_RESTART
                else if (clr_idx_q == LAST_SET)   state_d = ST_READY; // T_SWEEP_DONE
            end
            ST_READY: begin
                if (flush)                        state_d = ST_CLEAR; // T_FLUSH
            end
            default:                              state_d = ST_CLEAR;
        endcase
    end

    // ---------------- handshake outputs ----------------
    always_comb begin
        clearing  = (state_q == ST_CLEAR);
        req_ready = (state_q == ST_READY) && !flush;
        accept    = req_valid && req_ready;
    end

    // ---------------- lookup datapath ----------------
    assign cur_valid = valid_q[req_set];
    assign cur_tag   = tag_q[req_set];
    assign cur_age   = age_q[req_set];
    assign use_resv  = req_persist && (resv_q != '0);
    assign sel_way   = hit ? hit_way : victim;

    for (genvar gi = 0; gi < WAYS; gi++) begin : g_fresh
        assign fresh_age[gi] = WAY_W'(gi);
    end

    prc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .line_valid (cur_valid),
        .line_tag   (cur_tag),
        .lookup_tag (req_tag),
        .hit        (hit),
        .hit_way    (hit_way)
    );

    prc_victim_pick #(.WAYS(WAYS)) u_victim (
        .line_valid (cur_valid),
        .line_age   (cur_age),
        .resv_ways  (resv_q),
        .use_resv   (use_resv),
        .victim     (victim)
    );

    prc_age_update #(.WAYS(WAYS)) u_age (
        .age_in    (cur_age),
        .touch_way (sel_way),
        .resv_ways (resv_q),
        .age_out   (next_age)
    );

    // ---------------- tag / valid / recency store ----------------
    always_ff @(posedge clk) begin
        if (clearing) begin
            valid_q[clr_idx_q] <= '0;
            age_q[clr_idx_q]   <= fresh_age;
        end else if (accept) begin
            valid_q[req_set][sel_way] <= 1'b1;
            tag_q[req_set][sel_way]   <= req_tag;
            age_q[req_set]            <= next_age;
        end
    end

    // ---------------- response register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_way         <= '0;
            rsp_evict_valid <= 1'b0;
            rsp_evict_tag   <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit         <= hit;
                rsp_way         <= sel_way;
                rsp_evict_valid <= !hit && cur_valid[victim];
                rsp_evict_tag   <= cur_tag[victim];
            end
        end
    end

endmodule

// File: rtl/persist_repl_checker.sv
module persist_repl_checker #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_persist,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic             rsp_evict_valid,
    input logic [WAY_W-1:0] resv_q,
    input logic             clearing
);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid && req_ready)); // R2

    AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_evict_valid); // R3

    AST_PERSIST_IN_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && $past(req_persist) && resv_q != '0) |-> (rsp_way < resv_q)); // R5

    AST_NORMAL_OUTSIDE_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !$past(req_persist)) |-> (rsp_way >= resv_q)); // R6

    AST_RESV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clearing && !$past(clearing)) |-> $stable(resv_q)); // R10

    AST_FLUSH_SWEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (clearing && !req_ready)); // R11

endmodule

bind persist_repl_ctrl persist_repl_checker #(.WAYS(WAYS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .flush           (flush),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_persist     (req_persist),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_way         (rsp_way),
    .rsp_evict_valid (rsp_evict_valid),
    .resv_q          (resv_q),
    .clearing        (clearing)
);

// File: tb/persist_repl_ctrl_tb.sv
`timescale 1ns/1ps
module persist_repl_ctrl_tb;

    localparam int WAYS  = 4;
    localparam int SETS  = 8;
    localparam int TAG_W = 12;
    localparam int WAY_W = $clog2(WAYS);
    localparam int SET_W = $clog2(SETS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic [WAY_W-1:0] cfg_resv = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [SET_W-1:0] req_set = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_persist = 1'b0;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [WAY_W-1:0] rsp_way;
    logic             rsp_evict_valid;
    logic [TAG_W-1:0] rsp_evict_tag;

    always #2 clk = ~clk;

    persist_repl_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_dut (
        .clk, .rst_n, .flush, .cfg_resv, .req_valid, .req_ready, .req_set,
        .req_tag, .req_persist, .rsp_valid, .rsp_hit, .rsp_way,
        .rsp_evict_valid, .rsp_evict_tag
    );

    int checks = 0;
    int errors = 0;

    // reference model: global timestamps, smallest stamp = least recent
    bit mv [SETS][WAYS];
    int mt [SETS][WAYS];
    int ms [SETS][WAYS];
    int mres = 0;
    int stamp = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_clear(input int r);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 1'b0;
                ms[s][w] = 0;
            end
        mres = r;
    endfunction

    function automatic int model_hit(input int s, input int t);
        for (int w = 0; w < WAYS; w++)
            if (mv[s][w] && mt[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int model_victim(input int s, input bit p);
        int lo, hi, best;
        lo = (p && mres > 0) ? 0 : mres;
        hi = (p && mres > 0) ? mres - 1 : WAYS - 1;
        for (int w = lo; w <= hi; w++)
            if (!mv[s][w]) return w;
        best = lo;
        for (int w = lo; w <= hi; w++)
            if (ms[s][w] < ms[s][best]) best = w;
        return best;
    endfunction

    // one request, checked against the model; req names the requirement under test
    task automatic do_req(input int s, input int t, input bit p, input string req);
        int hw, vw, ew;
        bit ev;
        @(negedge clk);
        req_valid = 1'b1; req_set = SET_W'(s); req_tag = TAG_W'(t); req_persist = p;
        chk(req_ready == 1'b1, "R1", "req_ready before request", int'(req_ready), 1);
        hw = model_hit(s, t);
        vw = (hw >= 0) ? hw : model_victim(s, p);
        ev = (hw < 0) && mv[s][vw];
        ew = mt[s][vw];
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2", "rsp_valid after accept", int'(rsp_valid), 1);
        chk(rsp_hit == (hw >= 0), req, "rsp_hit", int'(rsp_hit), int'(hw >= 0));
        chk(int'(rsp_way) == vw, req, "rsp_way", int'(rsp_way), vw);
        chk(rsp_evict_valid == ev, "R9", "rsp_evict_valid", int'(rsp_evict_valid), int'(ev));
        if (ev)
            chk(int'(rsp_evict_tag) == ew, "R9", "rsp_evict_tag", int'(rsp_evict_tag), ew);
        stamp++;
        mv[s][vw] = 1'b1;
        mt[s][vw] = t;
        ms[s][vw] = stamp;
    endtask

    task automatic do_flush(input int r);
        int n;
        @(negedge clk);
        cfg_resv = WAY_W'(r);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        n = 1;
        while (!req_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == SETS + 1, "R1", "flush sweep cycles", n, SETS + 1);
        model_clear(r);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd1207));
        // ---------- R1 reset sweep ----------
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        n = 0;
        while (!req_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == SETS, "R1", "reset sweep cycles", n, SETS);
        model_clear(0);

        // ---------- R4 plain LRU with R = 0, R7 invalid first ----------
        for (int t = 1; t <= 4; t++) do_req(0, t, 1'b0, "R7");
        do_req(0, 1, 1'b0, "R3");
        do_req(0, 5, 1'b0, "R4");     // way1 (tag 2) oldest
        do_req(0, 6, 1'b1, "R4");     // persisting falls back to all ways
        do_req(0, 5, 1'b1, "R3");     // hit regardless of hint
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2", "rsp_valid single cycle", int'(rsp_valid), 0);

        // ---------- R5 / R6 with R = 2 ----------
        do_flush(2);
        do_req(1, 1, 1'b0, "R6");
        do_req(1, 2, 1'b0, "R6");
        do_req(1, 3, 1'b0, "R6");
        do_req(1, 10, 1'b1, "R5");
        do_req(1, 11, 1'b1, "R5");
        do_req(1, 12, 1'b1, "R8");
        do_req(1, 11, 1'b0, "R3");    // streaming hit on a persisting line
        do_req(1, 4, 1'b0, "R6");
        do_req(1, 3, 1'b0, "R9");     // new tag 3 hits where it was installed

        // ---------- R10 cfg change without flush is ignored ----------
        @(negedge clk);
        cfg_resv = '0;
        do_req(1, 13, 1'b1, "R10");
        do_req(1, 14, 1'b0, "R10");

        // ---------- R11 flush beats a request ----------
        @(negedge clk);
        cfg_resv = WAY_W'(1);
        flush = 1'b1;
        req_valid = 1'b1; req_set = '0; req_tag = TAG_W'(5); req_persist = 1'b0;
        #0.5;
        chk(req_ready == 1'b0, "R11", "req_ready with flush", int'(req_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        req_valid = 1'b0;
        chk(rsp_valid == 1'b0, "R11", "no response to flushed request", int'(rsp_valid), 0);
        n = 1;
        while (!req_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n == SETS + 1, "R1", "flush sweep cycles", n, SETS + 1);
        model_clear(1);
        do_req(0, 5, 1'b0, "R1");     // previously valid tag now misses

        // ---------- constrained random, every reservation size ----------
        for (int r = 0; r < WAYS; r++) begin
            do_flush(r);
            for (int k = 0; k < 300; k++) begin
                int s, t;
                bit p;
                s = int'($urandom_range(0, 1));
                t = int'($urandom_range(0, 11));
                p = ($urandom_range(0, 9) < 3);
                do_req(s, t, p, (r == 0) ? "R4" : (p ? "R5" : "R6"));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule